// File: doc/BRIEF.md
# DAC Power Mode Sequencer

This block governs the power state of a single-channel, low-power voltage DAC with a selectable internal reference. A serial front end decodes each incoming 16-bit word and hands over a command event: a 4-bit command code and two configuration bits, the upper two data bits of the word. From these events the sequencer keeps one of three modes: active, standby or off. It drives the enable of the reference and the enable of the output buffer. It also holds the 2-bit reference-level select.

When the converter leaves standby or off, the output needs time to settle before it can be trusted. A single down-counter covers this wait. Its load value is short when the reference was kept alive in standby and longer when the reference has to restart after being off. The output-valid flag stays low until the count reaches zero.

Command events arrive as single-cycle strobes on `cmd_valid`. The block takes one event per cycle and never applies back-pressure, so it has no ready signal. Outputs depend only on internal state, never directly on the inputs in the same cycle.

Top module: `dac_pwr_seq`

## Requirements
- R1: The mode is reported on `pwr_mode` as 00 = active, 01 = standby, 10 = off, and never 11. Active drives `ref_en`=1 and `buf_en`=1. Standby drives `ref_en`=1 and `buf_en`=0. Off drives both enables to 0.
- R2: Command code 1110 puts the block in off mode on the clock edge that accepts it, from any mode. Any wake-up count still running is cancelled.
- R3: Command code 1100 moves the block to standby only when it is in active mode. In standby or off mode it leaves the mode unchanged.
- R4: Command codes 1101, 1000, 1001 and 1111 return the block to active mode from standby or off. In active mode they change neither the mode nor a running wake-up count.
- R5: Command codes 1100, 1101 and 1110 load `ref_sel` from `cmd_cfg` in every mode, with `cmd_cfg[1]` as the upper select bit. All other codes leave `ref_sel` unchanged.
- R6: During and after reset the block is in active mode with `ref_sel`=00, both enables high and `out_valid`=1, which stands for a valid zero-scale output.
- R7: After a return from standby, `out_valid` stays low for exactly `STBY_WAKE_CYC` cycles, counted from the cycle after the accepting edge, and is then high.
- R8: After a return from off mode, `out_valid` stays low for exactly `OFF_WAKE_CYC` cycles, and is then high.
- R9: Command codes 0000, 0001 and every other code not named in R2 to R5 change neither the mode, nor `ref_sel`, nor the outputs.
- R10: `out_valid` is low in standby and in off mode.
- R11: While `cmd_valid` is low, `cmd_code` and `cmd_cfg` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Strobe: a decoded command is present this cycle |
| cmd_code | input | 4 | Command code of the event |
| cmd_cfg | input | 2 | Upper two data bits of the word (reference select) |
| ref_en | output | 1 | Reference enable |
| buf_en | output | 1 | Output buffer enable (low means high impedance) |
| out_valid | output | 1 | Output valid: active mode and wake-up count finished |
| pwr_mode | output | 2 | Current mode (00 active, 01 standby, 10 off) |
| ref_sel | output | 2 | Reference level select |

## Verification
On every cycle, the assertions check the following:
- the mode never takes the unused encoding;
- off mode disables both the reference and the buffer;
- standby is never entered from any mode other than active;
- a shutdown command always lands in off mode;
- nothing moves without a command strobe;
- the first active cycle after a wake-up reports the output as not valid.

The exact lengths of the two wake-up windows need the bench's scenarios and its per-cycle reference model. So do the facts that a repeated wake command does not restart the count, that a shutdown cancels a running count, and that the reference select loads even when a standby request is refused in off mode.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_STBY   = 2'b01,
    MODE_OFF    = 2'b10
  } pwr_mode_e;

  // command codes whose values are fixed by the serial word
  localparam logic [3:0] OP_UPDATE    = 4'b1000;
  localparam logic [3:0] OP_LOAD_UPD  = 4'b1001;
  localparam logic [3:0] OP_STBY      = 4'b1100;
  localparam logic [3:0] OP_RESUME    = 4'b1101;
  localparam logic [3:0] OP_OFF       = 4'b1110;
  localparam logic [3:0] OP_LOAD_UPD2 = 4'b1111;

  typedef struct packed {
    logic wake;      // request to return to active mode
    logic stby;      // request to enter standby
    logic off;       // request to power everything down
    logic sel_load;  // load the reference select from the config bits
  } cmd_ev_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_pwr_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  output cmd_ev_t    ev
);

  always_comb begin
    ev = '0;
    if (cmd_valid) begin
      unique case (cmd_code)
        OP_UPDATE, OP_LOAD_UPD, OP_LOAD_UPD2: ev.wake = 1'b1;
        OP_RESUME: begin
          ev.wake     = 1'b1;
          ev.sel_load = 1'b1;
        end
        OP_STBY: begin
          ev.stby     = 1'b1;
          ev.sel_load = 1'b1;
        end
        OP_OFF: begin
          ev.off      = 1'b1;
          ev.sel_load = 1'b1;
        end
        default: ev = '0;
      endcase
    end
  end

endmodule

// File: rtl/dac_mode_fsm.sv
module dac_mode_fsm
  import dac_pwr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_ev_t          ev,
  input  logic [SEL_W-1:0] cfg,
  output pwr_mode_e        mode,
  output logic [SEL_W-1:0] ref_sel,
  output logic             wake_short,
  output logic             wake_long,
  output logic             cancel
);

  logic stby_ok;

  always_comb begin
    stby_ok    = ev.stby && (mode == MODE_ACTIVE);
    wake_short = ev.wake && (mode == MODE_STBY);
    wake_long  = ev.wake && (mode == MODE_OFF);
    cancel     = ev.off || stby_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_ACTIVE;
    end else if (ev.off) begin
      mode <= MODE_OFF;
    end else if (stby_ok) begin
      mode <= MODE_STBY;
    end else if (ev.wake) begin
      mode <= MODE_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel <= '0;
    end else if (ev.sel_load) begin
      ref_sel <= cfg;
    end
  end

endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
  parameter int SHORT_CYC = 100000,
  parameter int LONG_CYC  = 950000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_short,
  input  logic start_long,
  input  logic cancel,
  output logic busy
);

  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1) < 1 ? 1 : $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cancel) begin
      cnt <= '0;
    end else if (start_short) begin
      cnt <= SHORT_V;
    end else if (start_long) begin
      cnt <= LONG_V;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dac_pwr_pkg::*;
#(
  parameter int STBY_WAKE_CYC = 100000,
  parameter int OFF_WAKE_CYC  = 950000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic [1:0] cmd_cfg,
  output logic       ref_en,
  output logic       buf_en,
  output logic       out_valid,
  output logic [1:0] pwr_mode,
  output logic [1:0] ref_sel
);

  cmd_ev_t   ev;
  pwr_mode_e mode;
  logic      wake_short;
  logic      wake_long;
  logic      cancel;
  logic      busy;

  dac_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .ev        (ev)
  );

  dac_mode_fsm #(.SEL_W(2)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .cfg        (cmd_cfg),
    .mode       (mode),
    .ref_sel    (ref_sel),
    .wake_short (wake_short),
    .wake_long  (wake_long),
    .cancel     (cancel)
  );

  dac_wake_timer #(
    .SHORT_CYC (STBY_WAKE_CYC),
    .LONG_CYC  (OFF_WAKE_CYC)
  ) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_short (wake_short),
    .start_long  (wake_long),
    .cancel      (cancel),
    .busy        (busy)
  );

  assign pwr_mode  = mode;
  assign ref_en    = (mode != MODE_OFF);
  assign buf_en    = (mode == MODE_ACTIVE);
  assign out_valid = buf_en && !busy;

endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       ref_en,
  input logic       buf_en,
  input logic       out_valid,
  input logic [1:0] pwr_mode,
  input logic [1:0] ref_sel
);

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b11);

  p_off_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10) |-> (!ref_en && !buf_en));

  p_off_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'b1110) |=> (pwr_mode == 2'b10));

  p_stby_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01 && $past(pwr_mode) != 2'b01) |-> ($past(pwr_mode) == 2'b00));

  p_wake_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && $past(pwr_mode) != 2'b00) |-> !out_valid);

  p_idle_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'b00) |-> !out_valid);

  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> ($stable(pwr_mode) && $stable(ref_sel)));

endmodule

bind dac_pwr_seq dac_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .ref_en    (ref_en),
  .buf_en    (buf_en),
  .out_valid (out_valid),
  .pwr_mode  (pwr_mode),
  .ref_sel   (ref_sel)
);

// File: tb/dac_pwr_seq_bench.sv
`timescale 1ns/1ps
module dac_pwr_seq_bench;

  localparam int WS = 12;
  localparam int WL = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'b0000;
  logic [1:0] cmd_cfg = 2'b00;
  logic       ref_en, buf_en, out_valid;
  logic [1:0] pwr_mode, ref_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural model state
  int m_mode = 0;
  int m_sel  = 0;
  int m_cnt  = 0;

  always #2 clk = ~clk;

  dac_pwr_seq #(.STBY_WAKE_CYC(WS), .OFF_WAKE_CYC(WL)) u_dac_pwr_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_cfg   (cmd_cfg),
    .ref_en    (ref_en),
    .buf_en    (buf_en),
    .out_valid (out_valid),
    .pwr_mode  (pwr_mode),
    .ref_sel   (ref_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: counter ticks, then the accepted command overrides
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_cnt = 0;
    end else begin
      if (m_cnt > 0) m_cnt--;
      if (cmd_valid) begin
        case (cmd_code)
          4'b1110: begin m_mode = 2; m_cnt = 0; m_sel = int'(cmd_cfg); end
          4'b1100: begin
            m_sel = int'(cmd_cfg);
            if (m_mode == 0) begin m_mode = 1; m_cnt = 0; end
          end
          4'b1101, 4'b1000, 4'b1001, 4'b1111: begin
            if (cmd_code == 4'b1101) m_sel = int'(cmd_cfg);
            if (m_mode == 1) begin m_mode = 0; m_cnt = WS; end
            else if (m_mode == 2) begin m_mode = 0; m_cnt = WL; end
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 mode", int'(pwr_mode), m_mode);
      chk("R5 ref_sel", int'(ref_sel), m_sel);
      chk("R1 ref_en", int'(ref_en), int'(m_mode != 2));
      chk("R1 buf_en", int'(buf_en), int'(m_mode == 0));
      chk("R7 out_valid", int'(out_valid), int'(m_mode == 0 && m_cnt == 0));
    end
  end

  task automatic send(input logic [3:0] code, input logic [1:0] cfg);
    cmd_valid = 1'b1; cmd_code = code; cmd_cfg = cfg;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'b0000; cmd_cfg = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R6 reset state, while still in reset
    chk("R6 mode", int'(pwr_mode), 0);
    chk("R6 ref_sel", int'(ref_sel), 0);
    chk("R6 out_valid", int'(out_valid), 1);
    chk("R6 enables", int'({ref_en, buf_en}), 3);
    rst_n = 1'b1;
    idle(2);

    // R4 resume in active: select loads, no count starts
    send(4'b1101, 2'b10);
    chk("R5 sel on resume", int'(ref_sel), 2);
    chk("R4 no restart in active", int'(out_valid), 1);

    // R3 standby from active
    send(4'b1100, 2'b01);
    chk("R3 standby entered", int'(pwr_mode), 1);
    chk("R1 standby enables", int'({ref_en, buf_en}), 2);
    chk("R10 invalid in standby", int'(out_valid), 0);
    send(4'b1100, 2'b11);
    chk("R3 standby repeat", int'(pwr_mode), 1);

    // R7 wake from standby
    send(4'b1000, 2'b00);
    chk("R7 active after wake", int'(pwr_mode), 0);
    idle(WS - 1);
    chk("R7 last low cycle", int'(out_valid), 0);
    idle(1);
    chk("R7 valid after window", int'(out_valid), 1);

    // R2 shutdown
    send(4'b1110, 2'b11);
    chk("R2 off entered", int'(pwr_mode), 2);
    chk("R1 off enables", int'({ref_en, buf_en}), 0);
    chk("R5 sel on off", int'(ref_sel), 3);

    // R3 standby refused in off, select still loads
    send(4'b1100, 2'b00);
    chk("R3 standby refused in off", int'(pwr_mode), 2);
    chk("R5 sel loads in off", int'(ref_sel), 0);

    // R9 codes with no effect
    send(4'b0011, 2'b11);
    send(4'b0001, 2'b10);
    send(4'b0000, 2'b01);
    send(4'b1010, 2'b11);
    chk("R9 mode unchanged", int'(pwr_mode), 2);
    chk("R9 sel unchanged", int'(ref_sel), 0);

    // R11 no strobe: code present but ignored
    cmd_code = 4'b1101; cmd_cfg = 2'b11;
    idle(3);
    cmd_code = 4'b0000; cmd_cfg = 2'b00;
    chk("R11 ignored mode", int'(pwr_mode), 2);
    chk("R11 ignored sel", int'(ref_sel), 0);

    // R8 wake from off, with a repeated wake mid-count (R4)
    send(4'b1111, 2'b00);
    idle(5);
    send(4'b1001, 2'b00);
    chk("R4 still counting", int'(out_valid), 0);
    idle(WL - 7);
    chk("R8 last low cycle", int'(out_valid), 0);
    idle(1);
    chk("R8 valid after window", int'(out_valid), 1);

    // R2 shutdown during a wake count cancels it
    send(4'b1110, 2'b01);
    send(4'b1101, 2'b10);
    idle(4);
    send(4'b1110, 2'b00);
    chk("R2 off during count", int'(pwr_mode), 2);
    send(4'b1101, 2'b01);
    idle(WL - 1);
    chk("R8 full count again", int'(out_valid), 0);
    idle(1);
    chk("R8 valid again", int'(out_valid), 1);

    // standby during a short count, then resume
    send(4'b1100, 2'b10);
    send(4'b1101, 2'b11);
    idle(3);
    send(4'b1100, 2'b00);
    chk("R3 standby during count", int'(pwr_mode), 1);
    send(4'b1000, 2'b00);
    idle(WS);
    chk("R7 valid after second wake", int'(out_valid), 1);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule